// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a fully associative page translation buffer. Each slot holds a virtual page tag, a physical page number, an address-space identifier, a global flag that makes the mapping visible to every address space, a read-enable mask and a write-enable mask with one bit per privilege mode, and two trap flags: one for reads and one for writes. A lookup presents a virtual page number and the current address-space identifier. In the same cycle the block returns a hit flag, the index of the matching slot and that slot's fields.

New mappings go into the slot named by a rotating replacement pointer. Three invalidation commands manage the contents. One wipes everything. One drops only the mappings that belong to a single address space and keeps the global ones. One drops the mappings for a single page that the given address space can see. The two entry counts in common use are 48 for an instruction-side instance and 64 for a data-side instance. The parameter default is 48.

Top module: `asn_tlb`

## Requirements
- R1: A slot hits only when three conditions hold: it is valid, its tag equals `lk_vpn`, and either its global flag is set or its stored identifier equals `lk_asn`. Lookup is combinational.
- R2: When several slots hit, `lk_idx` reports the lowest-numbered one, and the field outputs come from that slot.
- R3: An insert writes the slot named by `next_slot` on the next clock edge and marks it valid. It overwrites any mapping already in that slot.
- R4: `next_slot` advances by one after each insert and wraps from ENTRIES-1 to 0. It holds its value when there is no insert and no wipe.
- R5: `fl_all` invalidates every slot and returns `next_slot` to 0.
- R6: `fl_nonglobal` invalidates every slot whose global flag is clear. Global slots keep their mappings.
- R7: `fl_page` invalidates every valid slot whose tag equals `fl_vpn` and whose global flag is set or whose identifier equals `fl_asn`. One command may remove several slots.
- R8: Flushes issued in the same cycle as an insert take effect first. The insert then lands normally and survives. After a wipe, the insert goes to slot 0 and `next_slot` becomes 1.
- R9: After reset no lookup hits and `next_slot` is 0.
- R10: On a miss, `lk_idx` and every field output read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Current address-space identifier |
| lk_hit | output | 1 | A slot matches |
| lk_idx | output | IDX_W | Index of the matching slot |
| lk_ppn | output | PPN_W | Physical page of the match |
| lk_global | output | 1 | Global flag of the match |
| lk_rd_en | output | MODE_W | Read-enable mask of the match |
| lk_wr_en | output | MODE_W | Write-enable mask of the match |
| lk_trap_rd | output | 1 | Trap-on-read flag of the match |
| lk_trap_wr | output | 1 | Trap-on-write flag of the match |
| ins_valid | input | 1 | Insert a mapping |
| ins_vpn | input | VPN_W | Tag to store |
| ins_ppn | input | PPN_W | Physical page to store |
| ins_asn | input | ASN_W | Identifier to store |
| ins_global | input | 1 | Global flag to store |
| ins_rd_en | input | MODE_W | Read-enable mask to store |
| ins_wr_en | input | MODE_W | Write-enable mask to store |
| ins_trap_rd | input | 1 | Trap-on-read flag to store |
| ins_trap_wr | input | 1 | Trap-on-write flag to store |
| fl_all | input | 1 | Invalidate everything |
| fl_nonglobal | input | 1 | Invalidate non-global slots |
| fl_page | input | 1 | Invalidate slots that match a page |
| fl_vpn | input | VPN_W | Page to invalidate |
| fl_asn | input | ASN_W | Address space for the page invalidation |
| next_slot | output | IDX_W | Replacement pointer |

## Verification
The bench builds the block with 4 slots, 3-bit page numbers, 2-bit identifiers, 4-bit physical pages and 2 privilege modes. With these values every page and identifier pair, 32 in all, can be looked up after each command. The pointer also wraps several times within a short run. The small table makes duplicate tags, mixed global and private copies of one page, and collisions between a flush and an insert easy to set up. A bench-side model built from the requirements predicts each of these cases.

// File: rtl/asn_tlb.sv
module asn_tlb #(
  parameter int ENTRIES = 48,
  parameter int VPN_W   = 30,
  parameter int PPN_W   = 28,
  parameter int ASN_W   = 8,
  parameter int MODE_W  = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASN_W-1:0]  lk_asn,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic              lk_global,
  output logic [MODE_W-1:0] lk_rd_en,
  output logic [MODE_W-1:0] lk_wr_en,
  output logic              lk_trap_rd,
  output logic              lk_trap_wr,
  input  logic              ins_valid,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  logic [PPN_W-1:0]  ins_ppn,
  input  logic [ASN_W-1:0]  ins_asn,
  input  logic              ins_global,
  input  logic [MODE_W-1:0] ins_rd_en,
  input  logic [MODE_W-1:0] ins_wr_en,
  input  logic              ins_trap_rd,
  input  logic              ins_trap_wr,
  input  logic              fl_all,
  input  logic              fl_nonglobal,
  input  logic              fl_page,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [ASN_W-1:0]  fl_asn,
  output logic [IDX_W-1:0]  next_slot
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld, glb, trd, twr, hit_vec, kill_vec;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [ASN_W-1:0]   asn_q [ENTRIES];
  logic [MODE_W-1:0]  rd_q  [ENTRIES];
  logic [MODE_W-1:0]  wr_q  [ENTRIES];
  logic [IDX_W-1:0]   ptr, slot, ptr_n, sel;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i]  = vld[i] && tag_q[i] == lk_vpn && (glb[i] || asn_q[i] == lk_asn);
    assign kill_vec[i] = fl_all || (fl_nonglobal && !glb[i]) ||
                         (fl_page && tag_q[i] == fl_vpn && (glb[i] || asn_q[i] == fl_asn));
  end

  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) sel = IDX_W'(i);
  end

  assign lk_hit     = |hit_vec;
  assign lk_idx     = lk_hit ? sel : '0;
  assign lk_ppn     = lk_hit ? ppn_q[sel] : '0;
  assign lk_global  = lk_hit && glb[sel];
  assign lk_rd_en   = lk_hit ? rd_q[sel] : '0;
  assign lk_wr_en   = lk_hit ? wr_q[sel] : '0;
  assign lk_trap_rd = lk_hit && trd[sel];
  assign lk_trap_wr = lk_hit && twr[sel];

  assign slot      = fl_all ? '0 : ptr;
  assign ptr_n     = ins_valid ? ((slot == LAST) ? '0 : slot + 1'b1) : slot;
  assign next_slot = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      ptr <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (ins_valid && slot == IDX_W'(i)) vld[i] <= 1'b1;
        else if (kill_vec[i])               vld[i] <= 1'b0;
      ptr <= ptr_n;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++)
      if (ins_valid && slot == IDX_W'(i)) begin
        tag_q[i] <= ins_vpn;
        ppn_q[i] <= ins_ppn;
        asn_q[i] <= ins_asn;
        rd_q[i]  <= ins_rd_en;
        wr_q[i]  <= ins_wr_en;
        glb[i]   <= ins_global;
        trd[i]   <= ins_trap_rd;
        twr[i]   <= ins_trap_wr;
      end
  end
endmodule

module asn_tlb_chk #(
  parameter int ENTRIES = 48,
  parameter int PPN_W   = 28,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_hit,
  input logic [IDX_W-1:0] lk_idx,
  input logic [PPN_W-1:0] lk_ppn,
  input logic             ins_valid,
  input logic             fl_all,
  input logic [IDX_W-1:0] next_slot
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    next_slot <= LAST); // R4
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !fl_all) |=> next_slot == (($past(next_slot) == LAST) ? '0 : $past(next_slot) + 1'b1)); // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_valid && !fl_all) |=> $stable(next_slot)); // R4
  AST_WIPE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_all && !ins_valid) |=> (!lk_hit && next_slot == '0)); // R5
  AST_WIPE_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_all && ins_valid) |=> next_slot == ((LAST == '0) ? '0 : IDX_W'(1))); // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_idx == '0 && lk_ppn == '0)); // R10
endmodule

bind asn_tlb asn_tlb_chk #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_ppn(lk_ppn),
  .ins_valid(ins_valid), .fl_all(fl_all), .next_slot(next_slot));

// File: tb/asn_tlb_bench.sv
module asn_tlb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, VW = 3, PW = 4, AW = 2, MW = 2, IW = 2;

  logic clk = 0, rst_n = 0;
  logic [VW-1:0] lk_vpn = '0, ins_vpn = '0, fl_vpn = '0;
  logic [AW-1:0] lk_asn = '0, ins_asn = '0, fl_asn = '0;
  logic [PW-1:0] ins_ppn = '0, lk_ppn;
  logic [MW-1:0] ins_rd_en = '0, ins_wr_en = '0, lk_rd_en, lk_wr_en;
  logic ins_valid = 0, ins_global = 0, ins_trap_rd = 0, ins_trap_wr = 0;
  logic fl_all = 0, fl_nonglobal = 0, fl_page = 0;
  logic lk_hit, lk_global, lk_trap_rd, lk_trap_wr;
  logic [IW-1:0] lk_idx, next_slot;

  int tests = 0, fails = 0;

  logic          m_v [N];
  logic [VW-1:0] m_tag [N];
  logic [AW-1:0] m_asn [N];
  logic          m_g [N];
  logic [10:0]   m_fld [N];
  int            m_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  asn_tlb #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW), .ASN_W(AW), .MODE_W(MW)) u_asn_tlb (.*);

  function automatic logic [10:0] fields_of(int v, int a, bit g);
    return {4'((v * 3 + a) % 16), 1'(g), 2'(v % 4), 2'((v + a) % 4), 1'(a % 2), 1'((v / 2) % 2)};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // model of the requirements: flush first, then insert
  task automatic op(bit ins, int v, int a, bit g, bit wipe, bit ng, bit pg, int fv, int fa);
    logic [10:0] f;
    f = fields_of(v, a, g);
    @(negedge clk);
    ins_valid = ins; ins_vpn = VW'(v); ins_asn = AW'(a); ins_global = g;
    {ins_ppn, ins_rd_en, ins_wr_en, ins_trap_rd, ins_trap_wr} = {f[10:7], f[5:0]};
    fl_all = wipe; fl_nonglobal = ng; fl_page = pg; fl_vpn = VW'(fv); fl_asn = AW'(fa);
    @(posedge clk);
    for (int i = 0; i < N; i++)
      if (m_v[i] && (wipe || (ng && !m_g[i]) ||
          (pg && m_tag[i] == VW'(fv) && (m_g[i] || m_asn[i] == AW'(fa))))) m_v[i] = 0;
    if (wipe) m_ptr = 0;
    if (ins) begin
      m_v[m_ptr] = 1; m_tag[m_ptr] = VW'(v); m_asn[m_ptr] = AW'(a);
      m_g[m_ptr] = g; m_fld[m_ptr] = f;
      m_ptr = (m_ptr + 1) % N;
    end
    #1;
    ins_valid = 0; fl_all = 0; fl_nonglobal = 0; fl_page = 0;
  endtask

  task automatic sweep(string req);
    int e; bit h;
    for (int v = 0; v < (1 << VW); v++)
      for (int a = 0; a < (1 << AW); a++) begin
        @(negedge clk);
        lk_vpn = VW'(v); lk_asn = AW'(a);
        #1;
        h = 0; e = 0;
        for (int i = N - 1; i >= 0; i--)
          if (m_v[i] && m_tag[i] == VW'(v) && (m_g[i] || m_asn[i] == AW'(a))) begin h = 1; e = i; end
        check(lk_hit == h, req, "hit", lk_hit, h);
        check(lk_idx == IW'(e), req, "index", lk_idx, e);
        check({lk_ppn, lk_global, lk_rd_en, lk_wr_en, lk_trap_rd, lk_trap_wr} == (h ? m_fld[e] : 11'd0),
              h ? "R1" : "R10", "fields",
              {lk_ppn, lk_global, lk_rd_en, lk_wr_en, lk_trap_rd, lk_trap_wr}, h ? m_fld[e] : 0);
      end
    check(next_slot == IW'(m_ptr), "R4", "next_slot", next_slot, m_ptr);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; tests++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_tag[i] = 0; m_asn[i] = 0; m_g[i] = 0; m_fld[i] = 0; end
    m_ptr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    sweep("R9");
    // R3 R4: fill and wrap
    op(1, 1, 0, 0, 0, 0, 0, 0, 0); check(next_slot == 1, "R4", "ptr", next_slot, 1);
    op(1, 2, 1, 1, 0, 0, 0, 0, 0);
    op(1, 1, 2, 0, 0, 0, 0, 0, 0);
    op(1, 3, 3, 0, 0, 0, 0, 0, 0); check(next_slot == 0, "R4", "wrap", next_slot, 0);
    sweep("R3");
    // R2: global copy of page 1 in slot 0 shadows private copy in slot 2
    op(1, 1, 3, 1, 0, 0, 0, 0, 0);
    sweep("R2");
    op(1, 5, 1, 0, 0, 0, 0, 0, 0);
    sweep("R3");
    // R7: removes global slot 0 and asn-2 slot 2
    op(0, 0, 0, 0, 0, 0, 1, 1, 2);
    sweep("R7");
    op(1, 6, 0, 1, 0, 0, 0, 0, 0);
    op(1, 7, 2, 0, 0, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 1, 0, 0, 0);
    sweep("R6");
    // R8: flush-page collides with insert of the same page
    op(1, 6, 0, 0, 0, 0, 1, 6, 0);
    sweep("R8");
    op(1, 4, 1, 0, 0, 1, 0, 0, 0);
    sweep("R8");
    op(1, 2, 2, 0, 1, 0, 0, 0, 0);
    check(next_slot == 1, "R8", "ptr after wipe+insert", next_slot, 1);
    sweep("R8");
    for (int k = 0; k < 13; k++) op(1, k % 8, k % 4, (k % 3) == 0, 0, 0, 0, 0, 0);
    sweep("R1");
    op(0, 0, 0, 0, 0, 0, 1, 4, 0);
    sweep("R7");
    op(0, 0, 0, 0, 1, 0, 0, 0, 0);
    sweep("R5");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule